// File: doc/BRIEF.md
# Serial Float Store Converter

This block turns a floating-point register value into the bit image written to memory by a store. The register value is always held in double layout: sign in bit 63, an 11-bit biased exponent in bits 62:52 and a 52-bit fraction in bits 51:0. One special case is a single-precision denormal held in the register. It is tagged by a zero exponent field, and its 23 fraction bits sit in bits 51:29. The kind input selects the store: 0 for a single-precision store, 1 for a double-precision store. A single image is returned in bits 31:0 of the result, with bits 63:32 zero.

Two cases need the mantissa moved by a variable distance. The block moves it one bit per clock instead of using a wide shifter, so its latency depends on the data:

- A single store whose exponent is too small for a normal single is shifted right into a single denormal.
- A double store of a held single denormal is shifted left until it is normalized.

Every other case takes one cycle. Bits shifted out are dropped. The cycles output reports the latency of each operation.

The controller has four states:

- **IDLE** waits for start. On an accepted start it moves to PASS, SHR or SHL, depending on the operand class.
- **PASS** always returns to IDLE after one cycle.
- **SHR** returns to IDLE on the edge that makes the last right shift.
- **SHL** returns to IDLE on the edge where the leading one reaches bit 23 of the 24-bit mantissa.

Each return to IDLE raises done for one cycle, with the result and cycles outputs valid.

Top module: `fp_store_cvt`

## Requirements
- R1: After reset, busy=0, ready=1, done=0, result=0 and cycles=0.
- R2: A start is accepted on a rising edge where ready=1 (ready is the inverse of busy). Busy is 1 from that edge until the edge that raises done. Done is a one-cycle pulse that rises exactly L rising edges after the accepting edge, where L is the value on cycles in that same cycle.
- R3: A start while busy=1 is ignored. It causes no extra done pulse and does not change the result of the operation in progress.
- R4: A single store (kind=0) with exponent e of 897 or more returns {32'b0, sign, (e-896) mod 256, bits 51:29} with L=1.
- R5: A single store with e from 1 to 896 takes the 24-bit mantissa {1, bits 51:29}. It shifts that mantissa right n times, with n = min(897-e, 23), one bit per cycle. It returns {32'b0, sign, 8'b0, low 23 bits} with L=n.
- R6: A single store with e=0 returns {32'b0, sign, 8'b0, bits 51:29} with L=1. This gives a signed zero when those bits are zero.
- R7: A double store (kind=1) with e=0 and nonzero bits 51:29 takes m={0, bits 51:29}. It shifts m left k times, one bit per cycle, until bit 23 of m is 1. It returns {sign, 11-bit 897-k, m[22:0], 29'b0} with L=k.
- R8: A double store with e=0 and bits 51:29 all zero returns {sign, 63'b0} with L=1.
- R9: A double store with e not 0 returns the operand unchanged with L=1.
- R10: The sign of the result equals the sign of the operand for every kind: bit 31 for a single store, bit 63 for a double store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to convert operand |
| kind | input | 1 | 0 = single-precision store, 1 = double-precision store |
| operand | input | 64 | Register value in double layout |
| ready | output | 1 | Block can accept start |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse, result and cycles valid |
| result | output | 64 | Memory image of the store |
| cycles | output | 5 | Latency of the finished operation |

## Verification
One operation can finish in the same cycle that the next one is accepted: done is high while the controller is already back in IDLE with ready=1. The bench provokes this by driving start in the first cycle ready returns, including runs of one-cycle operations. That gives done pulses on consecutive edges. The scoreboard judges each pulse against the expected image, the expected cycles value and the exact cycle in which done should appear. Start pulses driven during a long right shift must then produce no done pulse of their own.

// File: rtl/fp_store_cvt_pkg.sv
package fp_store_cvt_pkg;
    parameter int DEXP_W  = 11;
    parameter int DFRAC_W = 52;
    parameter int SEXP_W  = 8;
    parameter int SFRAC_W = 23;

    localparam int DW          = 1 + DEXP_W + DFRAC_W;
    localparam int SW          = 1 + SEXP_W + SFRAC_W;
    localparam int MANT_W      = SFRAC_W + 1;
    localparam int CNT_W       = $clog2(MANT_W + 1);
    localparam int DBIAS       = (2 ** (DEXP_W - 1)) - 1;
    localparam int SBIAS       = (2 ** (SEXP_W - 1)) - 1;
    localparam int BIAS_GAP    = DBIAS - SBIAS;
    localparam int DENORM_BASE = BIAS_GAP + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PASS,
        ST_SHR,
        ST_SHL
    } state_t;

    typedef enum logic [1:0] {
        PATH_FAST,
        PATH_SHR,
        PATH_SHL
    } path_t;
endpackage

// File: rtl/fp_store_cvt_classify.sv
module fp_store_cvt_classify
    import fp_store_cvt_pkg::*;
(
    input  logic [DW-1:0]     operand,
    input  logic              kind,
    output path_t             path,
    output logic [DW-1:0]     fast_res,
    output logic [MANT_W-1:0] mant_init,
    output logic [CNT_W-1:0]  shr_cnt
);
    logic               sign;
    logic [DEXP_W-1:0]  expo;
    logic [SFRAC_W-1:0] f_hi;
    logic [DEXP_W-1:0]  gap;
    logic [SEXP_W-1:0]  rebias;

    assign sign   = operand[DW-1];
    assign expo   = operand[DW-2 -: DEXP_W];
    assign f_hi   = operand[DFRAC_W-1 -: SFRAC_W];
    assign gap    = DEXP_W'(DENORM_BASE) - expo;
    assign rebias = expo[SEXP_W-1:0] - SEXP_W'(BIAS_GAP);

    always_comb begin
        path      = PATH_FAST;
        fast_res  = '0;
        mant_init = '0;
        shr_cnt   = '0;
        if (!kind) begin
            if (expo == '0) begin
                fast_res = {{(DW-SW){1'b0}}, sign, {SEXP_W{1'b0}}, f_hi};
            end else if (expo <= DEXP_W'(BIAS_GAP)) begin
                path      = PATH_SHR;
                mant_init = {1'b1, f_hi};
                shr_cnt   = (gap > DEXP_W'(SFRAC_W)) ? CNT_W'(SFRAC_W) : gap[CNT_W-1:0];
            end else begin
                fast_res = {{(DW-SW){1'b0}}, sign, rebias, f_hi};
            end
        end else begin
            if (expo == '0 && f_hi != '0) begin
                path      = PATH_SHL;
                mant_init = {1'b0, f_hi};
            end else if (expo == '0) begin
                fast_res = {sign, {(DW-1){1'b0}}};
            end else begin
                fast_res = operand;
            end
        end
    end
endmodule

// File: rtl/fp_store_cvt_shifter.sv
module fp_store_cvt_shifter
    import fp_store_cvt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               shr,
    input  logic               shl,
    input  logic [MANT_W-1:0]  mant_in,
    input  logic [CNT_W-1:0]   cnt_in,
    input  logic               sign_in,
    output logic [CNT_W-1:0]   cnt_q,
    output logic               sign_q,
    output logic [SFRAC_W-1:0] mant_r,
    output logic [MANT_W-1:0]  mant_l,
    output logic [DEXP_W-1:0]  exp_dec,
    output logic [CNT_W-1:0]   steps_inc
);
    logic [MANT_W-1:0] mant_q;
    logic [DEXP_W-1:0] exp_q;
    logic [CNT_W-1:0]  steps_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mant_q  <= '0;
            cnt_q   <= '0;
            exp_q   <= DEXP_W'(DENORM_BASE);
            steps_q <= '0;
            sign_q  <= 1'b0;
        end else if (load) begin
            mant_q  <= mant_in;
            cnt_q   <= cnt_in;
            exp_q   <= DEXP_W'(DENORM_BASE);
            steps_q <= '0;
            sign_q  <= sign_in;
        end else if (shr) begin
            mant_q  <= mant_q >> 1;
            cnt_q   <= cnt_q - CNT_W'(1);
            steps_q <= steps_inc;
        end else if (shl) begin
            mant_q  <= mant_l;
            exp_q   <= exp_dec;
            steps_q <= steps_inc;
        end
    end

    assign mant_r    = mant_q[MANT_W-1:1];
    assign mant_l    = mant_q << 1;
    assign exp_dec   = exp_q - DEXP_W'(1);
    assign steps_inc = steps_q + CNT_W'(1);
endmodule

// File: rtl/fp_store_cvt.sv
module fp_store_cvt
    import fp_store_cvt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             kind,
    input  logic [DW-1:0]    operand,
    output logic             ready,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    result,
    output logic [CNT_W-1:0] cycles
);
    state_t             state_q, state_d;
    path_t              path;
    logic [DW-1:0]      fast_res;
    logic [MANT_W-1:0]  mant_init;
    logic [CNT_W-1:0]   shr_cnt;
    logic [CNT_W-1:0]   cnt_q;
    logic               sign_q;
    logic [SFRAC_W-1:0] mant_r;
    logic [MANT_W-1:0]  mant_l;
    logic [DEXP_W-1:0]  exp_dec;
    logic [CNT_W-1:0]   steps_inc;
    logic               accept;
    logic               shr_last;
    logic               shl_last;

    assign busy     = (state_q != ST_IDLE);
    assign ready    = ~busy;
    assign accept   = start && (state_q == ST_IDLE);
    assign shr_last = (cnt_q == CNT_W'(1));
    assign shl_last = mant_l[MANT_W-1];

    fp_store_cvt_classify u_classify (
        .operand   (operand),
        .kind      (kind),
        .path      (path),
        .fast_res  (fast_res),
        .mant_init (mant_init),
        .shr_cnt   (shr_cnt)
    );

    fp_store_cvt_shifter u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .shr       (state_q == ST_SHR),
        .shl       (state_q == ST_SHL),
        .mant_in   (mant_init),
        .cnt_in    (shr_cnt),
        .sign_in   (operand[DW-1]),
        .cnt_q     (cnt_q),
        .sign_q    (sign_q),
        .mant_r    (mant_r),
        .mant_l    (mant_l),
        .exp_dec   (exp_dec),
        .steps_inc (steps_inc)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (path)
                        PATH_SHR: state_d = ST_SHR;
                        PATH_SHL: state_d = ST_SHL;
                        default:  state_d = ST_PASS;
                    endcase
                end
            end
            ST_PASS: state_d = ST_IDLE;
            ST_SHR:  if (shr_last) state_d = ST_IDLE;
            ST_SHL:  if (shl_last) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
            cycles <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && path == PATH_FAST) result <= fast_res;
                end
                ST_PASS: begin
                    done   <= 1'b1;
                    cycles <= CNT_W'(1);
                end
                ST_SHR: begin
                    if (shr_last) begin
                        done   <= 1'b1;
                        result <= {{(DW-SW){1'b0}}, sign_q, {SEXP_W{1'b0}}, mant_r};
                        cycles <= steps_inc;
                    end
                end
                ST_SHL: begin
                    if (shl_last) begin
                        done   <= 1'b1;
                        result <= {sign_q, exp_dec, mant_l[SFRAC_W-1:0], {(DFRAC_W-SFRAC_W){1'b0}}};
                        cycles <= steps_inc;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/fp_store_cvt_chk.sv
module fp_store_cvt_chk
    import fp_store_cvt_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               kind,
    input logic               op_sign,
    input logic [DEXP_W-1:0]  op_exp,
    input logic [SFRAC_W-1:0] op_fhi,
    input logic               ready,
    input logic               busy,
    input logic               done,
    input logic [DW-1:0]      result,
    input logic [CNT_W-1:0]   cycles
);
    logic cap_kind, cap_sign, cap_zero, cap_shr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_kind <= 1'b0;
            cap_sign <= 1'b0;
            cap_zero <= 1'b0;
            cap_shr  <= 1'b0;
        end else if (start && ready) begin
            cap_kind <= kind;
            cap_sign <= op_sign;
            cap_zero <= (op_exp == '0) && (op_fhi == '0);
            cap_shr  <= !kind && (op_exp != '0) && (op_exp <= DEXP_W'(BIAS_GAP));
        end
    end

    a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    a_r2_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r5_cycles_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles >= CNT_W'(1)) && (cycles <= CNT_W'(SFRAC_W)));

    a_r10_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((cap_kind ? result[DW-1] : result[SW-1]) == cap_sign));

    // covers R6 and R8: zero class takes one cycle and keeps only the sign
    a_r8_zero_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_zero) |-> (cycles == CNT_W'(1)) &&
            (cap_kind ? (result[DW-2:0] == '0) : (result[SW-2:0] == '0)));

    a_r5_denorm_exp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_shr) |-> (result[SW-2 -: SEXP_W] == '0) && (result[DW-1:SW] == '0));
endmodule

bind fp_store_cvt fp_store_cvt_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .kind    (kind),
    .op_sign (operand[fp_store_cvt_pkg::DW-1]),
    .op_exp  (operand[fp_store_cvt_pkg::DW-2 -: fp_store_cvt_pkg::DEXP_W]),
    .op_fhi  (operand[fp_store_cvt_pkg::DFRAC_W-1 -: fp_store_cvt_pkg::SFRAC_W]),
    .ready   (ready),
    .busy    (busy),
    .done    (done),
    .result  (result),
    .cycles  (cycles)
);

// File: tb/fp_store_cvt_bench.sv
`timescale 1ns/100ps
module fp_store_cvt_bench;
    import fp_store_cvt_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             kind = 1'b0;
    logic [DW-1:0]    operand = '0;
    logic             ready, busy, done;
    logic [DW-1:0]    result;
    logic [CNT_W-1:0] cycles;

    always #2.5 clk = ~clk;

    fp_store_cvt u_fp_store_cvt (
        .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .operand(operand),
        .ready(ready), .busy(busy), .done(done), .result(result), .cycles(cycles)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    typedef struct {
        logic [63:0] res;
        int          lat;
        int          due;
        string       tag;
    } item_t;
    item_t sb[$];

    task automatic check_val(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [63:0] op, input logic k,
                                  output logic [63:0] res, output int lat);
        logic        s;
        logic [10:0] e;
        logic [22:0] f;
        logic [23:0] m;
        logic [10:0] x;
        int          n;
        s = op[63];
        e = op[62:52];
        f = op[51:29];
        lat = 1;
        if (!k) begin
            if (e == 0) begin
                res = {32'h0, s, 8'h0, f};
            end else if (e <= 11'd896) begin
                n = 897 - int'(e);
                if (n > 23) n = 23;
                m = {1'b1, f};
                for (int i = 0; i < n; i++) m = m >> 1;
                res = {32'h0, s, 8'h0, m[22:0]};
                lat = n;
            end else begin
                x = e - 11'd896;
                res = {32'h0, s, x[7:0], f};
            end
        end else begin
            if (e == 0 && f == 0) begin
                res = {s, 63'h0};
            end else if (e == 0) begin
                m = {1'b0, f};
                n = 0;
                while (!m[23]) begin
                    m = m << 1;
                    n++;
                end
                x = 11'(897 - n);
                res = {s, x, m[22:0], 29'h0};
                lat = n;
            end else begin
                res = op;
            end
        end
    endfunction

    function automatic logic [63:0] mk(input logic s, input int e, input logic [22:0] f, input logic [28:0] lo);
        mk = {s, 11'(e), f, lo};
    endfunction

    // driver: called at a falling edge; starts in the first cycle ready is high
    task automatic issue(input logic [63:0] op, input logic k, input string tag);
        item_t it;
        while (!ready) @(negedge clk);
        start   = 1'b1;
        operand = op;
        kind    = k;
        @(negedge clk);
        start = 1'b0;
        model(op, k, it.res, it.lat);
        it.due = cyc + it.lat;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R3 unexpected done actual=%h expected=none", result);
            end else begin
                item_t it;
                it = sb.pop_front();
                check_val({it.tag, " result"}, result, it.res);
                check_val({it.tag, " cycles"}, 64'(cycles), 64'(it.lat));
                check_val({"R2 done timing ", it.tag}, 64'(cyc), 64'(it.due));
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 busy", 64'(busy), 64'(0));
        check_val("R1 ready", 64'(ready), 64'(1));
        check_val("R1 done", 64'(done), 64'(0));
        check_val("R1 result", result, 64'h0);
        check_val("R1 cycles", 64'(cycles), 64'(0));

        issue(64'h3FF0_0000_0000_0000, 1'b0, "R4 one");
        check_val("R2 busy after accept", 64'(busy), 64'(1));
        check_val("R2 ready while busy", 64'(ready), 64'(0));
        issue(mk(1'b1, 1000, 23'h5A5A5A, 29'h1FFFFFFF), 1'b0, "R4 neg");
        issue(mk(1'b0, 896, 23'h000000, 29'h0), 1'b0, "R5 n1");
        issue(mk(1'b0, 890, 23'h7FFFFF, 29'h0), 1'b0, "R5 n7");
        issue(mk(1'b1, 875, 23'h400001, 29'h0), 1'b0, "R5 n22");
        issue(mk(1'b0, 874, 23'h123456, 29'h0), 1'b0, "R5 n23");
        issue(mk(1'b1, 1, 23'h7FFFFF, 29'h0), 1'b0, "R5 cap");
        issue(mk(1'b1, 0, 23'h0, 29'h0), 1'b0, "R6 zero");
        issue(mk(1'b0, 0, 23'h000123, 29'h0ABC), 1'b0, "R6 held");
        issue(mk(1'b0, 0, 23'h400000, 29'h0), 1'b1, "R7 k1");
        issue(mk(1'b1, 0, 23'h000001, 29'h0), 1'b1, "R7 k23");
        issue(mk(1'b0, 0, 23'h00F00F, 29'h0), 1'b1, "R7 mid");
        issue(mk(1'b1, 0, 23'h0, 29'h1234), 1'b1, "R8 zero");
        issue(64'h4009_21FB_5444_2D18, 1'b1, "R9 pass");
        issue(64'hC000_0000_0000_0001, 1'b1, "R10 pass");

        // R3: start pulses during a 17-cycle right shift
        issue(mk(1'b1, 880, 23'h3C3C3C, 29'h0), 1'b0, "R3 long");
        operand = 64'h3FF0_0000_0000_0000;
        kind    = 1'b1;
        start   = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        check_val("R3 still busy", 64'(busy), 64'(1));

        // back-to-back fast ops: done on consecutive edges
        issue(64'h3FF8_0000_0000_0000, 1'b0, "R4 b2b");
        issue(64'h8000_0000_0000_0000, 1'b1, "R8 b2b");
        issue(64'h7FE0_0000_0000_0000, 1'b1, "R9 b2b");
        issue(mk(1'b0, 895, 23'h0, 29'h0), 1'b0, "R5 b2b");

        for (int i = 0; i < 60 && sb.size() != 0; i++) @(negedge clk);
        repeat (5) @(negedge clk);
        check_val("R2 all results seen", 64'(sb.size()), 64'(0));
        check_val("R2 idle at end", 64'(busy), 64'(0));

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule